// File: doc/BRIEF.md
# Prefixed Opcode Sequencer

This block sits in the fetch path of an 8-bit CPU whose instruction set extends its base opcode page with the prefix bytes DD, FD, CB and ED. Instruction bytes arrive one per valid/ready handshake. The block tracks which prefixes have been seen and captures the signed displacement that indexed forms carry. When an instruction is complete it emits one decoded record. The record gives the page, the index register chosen, the final opcode byte, the displacement, and flags for how the operand is addressed. Execution, the memory interface and interrupts belong to other blocks.

The less obvious behaviour of the prefix scheme is modelled. An index prefix in front of an opcode that never touches HL is dropped. In a stack of index prefixes, each earlier prefix retires as a one-byte no-op. In the indexed CB form the displacement comes before the operation byte. Undefined ED opcodes are reported as two-byte no-ops. A 7-bit refresh counter advances for every fetched prefix or opcode byte. Displacement bytes do not advance it.

The record is registered and stays stable until the next one. A one-cycle `dec_valid` pulse marks each new record.

Top module: `zps_sequencer`

## Requirements
- R1: After reset is released, `dec_valid` is 0 and `refresh_cnt` is 0. `in_ready` reads 1 from the second clock edge onward.
- R2: Each completed instruction raises `dec_valid` for exactly one cycle, in the cycle after its last byte is accepted. A byte other than DD, FD, CB or ED in the open state forms a record by itself. That record has page 0 (base), index 0 (none), all flags 0 and displacement 0. Page codes: 0 base, 1 CB, 2 ED. Index codes: 0 none, 1 DD-selected register, 2 FD-selected register.
- R3: DD selects index code 1 and FD selects index code 2 for base opcodes that use HL as a 16-bit register: 09, 19, 29, 39, 21, 22, 2A, 23, 2B, E1, E3, E5, E9, F9. These records have `dec_mem_idx` = 0 and `dec_half_idx` = 0.
- R4: An index prefix followed by a base opcode that does not use H, L or HL is dropped. One record is produced, with index 0 and the opcode unchanged (for example DD FF gives opcode FF, index 0).
- R5: An indexed memory opcode waits for one further displacement byte. The opcodes are 34, 35, 36, any 40–7F other than 76 whose source or destination field (bits 2:0 or 5:3) is 6, and any 80–BF with source field 6. The record carries `dec_mem_idx` = 1 and that displacement.
- R6: With an index prefix, an opcode whose H or L field (code 4 or 5) is used and that has no field equal to 6 sets `dec_half_idx` = 1 and takes no displacement. An opcode that also has a memory field (for example 66) sets `dec_mem_idx` and keeps `dec_half_idx` at 0.
- R7: The indexed CB sequence is prefix, CB, displacement, then operation byte. It gives page 1, the prefix's index code, `dec_mem_idx` = 1, the displacement and the operation byte as opcode.
- R8: In an indexed CB record, `dec_copyback` = 1 exactly when the operation's register field (bits 2:0) is not 6 and the operation is not a bit test (bits 7:6 not 01).
- R9: ED followed by an opcode in 00–3F or C0–FF gives page 2 with `dec_nop` = 1. ED opcodes in 40–BF give `dec_nop` = 0.
- R10: ED 77 and ED 7F give page 2 with `dec_pv_ie` = 1 and `dec_nop` = 0. Every other record has `dec_pv_ie` = 0.
- R11: When a DD or FD prefix, or ED, follows an index prefix, the earlier prefix is emitted as its own record: page 0, index 0, `dec_nop` = 1, opcode equal to that prefix byte. Only the last index prefix applies to the instruction that follows.
- R12: `refresh_cnt` bits 6:0 increase by one for every accepted prefix or opcode byte and wrap from 7F to 00. Bit 7 is never changed. Displacement bytes, and the operation byte of an indexed CB sequence, do not count.
- R13: CB without an index prefix gives page 1, index 0, `dec_mem_idx` = 0 and the following byte as opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| dec_valid | output | 1 | One-cycle pulse: new record |
| dec_index | output | 2 | Index selection: 0 none, 1 DD, 2 FD |
| dec_page | output | 2 | Opcode page: 0 base, 1 CB, 2 ED |
| dec_opcode | output | 8 | Final opcode byte (or retired prefix byte) |
| dec_disp | output | 8 | Displacement for indexed memory operands, else 0 |
| dec_mem_idx | output | 1 | Memory operand is index plus displacement |
| dec_half_idx | output | 1 | H/L fields name halves of the index register |
| dec_copyback | output | 1 | Indexed CB result also written to named register |
| dec_nop | output | 1 | Record is a no-op (retired prefix or undefined ED) |
| dec_pv_ie | output | 1 | Record only copies interrupt enable into P/V |
| refresh_cnt | output | 8 | Refresh counter |

## Verification
The bench aims at the orderings where a sequencer commonly slips. One is the indexed CB form, where swapping the displacement and the operation byte would report the opcode in the displacement field. Another is a prefix in front of an opcode that does not use HL; a design that kept it would report an index on an ordinary instruction. Stacked DD/FD prefixes and DD before ED are checked for the extra no-op record that a careless design either drops or attaches to the wrong index. The refresh counter is checked across displacement bytes, indexed CB operation bytes and a 7-bit wrap, where a design that counted every byte or let the carry reach bit 7 would drift.

// File: rtl/zps_pkg.sv
package zps_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] PFX_X  = 8'hDD;
    localparam logic [BYTE_W-1:0] PFX_Y  = 8'hFD;
    localparam logic [BYTE_W-1:0] PFX_CB = 8'hCB;
    localparam logic [BYTE_W-1:0] PFX_ED = 8'hED;
    localparam logic [2:0]        MEM_FIELD = 3'd6;

    localparam logic [1:0] IDX_NONE = 2'd0;
    localparam logic [1:0] IDX_X    = 2'd1;
    localparam logic [1:0] IDX_Y    = 2'd2;

    localparam logic [1:0] PG_BASE = 2'd0;
    localparam logic [1:0] PG_CB   = 2'd1;
    localparam logic [1:0] PG_ED   = 2'd2;

    typedef enum logic [2:0] {
        S_OPEN,
        S_IDX,
        S_DISP,
        S_XCB_D,
        S_XCB_OP,
        S_CB,
        S_ED
    } seq_e;

    typedef struct packed {
        logic [1:0]        idx;
        logic [1:0]        page;
        logic [BYTE_W-1:0] op;
        logic [BYTE_W-1:0] disp;
        logic              mem;
        logic              half;
        logic              cb;
        logic              nop;
        logic              pv;
    } rec_t;

    typedef struct packed {
        seq_e              st;
        logic [1:0]        idx;
        logic [BYTE_W-1:0] op;
        logic [BYTE_W-1:0] disp;
        rec_t              rec;
        logic              vld;
        logic              rdy;
    } seq_t;

    function automatic logic [BYTE_W-1:0] pfx_of(input logic [1:0] idx);
        return (idx == IDX_X) ? PFX_X : PFX_Y;
    endfunction

endpackage

// File: rtl/zps_classify.sv
module zps_classify
    import zps_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output logic              mem_op,
    output logic              half_op,
    output logic              word_op
);

    logic [2:0] dst_f;
    logic [2:0] src_f;
    logic       dst_half;
    logic       src_half;

    always_comb begin
        dst_f    = op[5:3];
        src_f    = op[2:0];
        dst_half = (dst_f == 3'd4) || (dst_f == 3'd5);
        src_half = (src_f == 3'd4) || (src_f == 3'd5);
        mem_op   = 1'b0;
        half_op  = 1'b0;
        word_op  = 1'b0;
        case (op[7:6])
            2'b00: begin
                if (op inside {8'h09, 8'h19, 8'h29, 8'h39, 8'h21, 8'h22, 8'h2A, 8'h23, 8'h2B})
                    word_op = 1'b1;
                if (op inside {8'h24, 8'h25, 8'h26, 8'h2C, 8'h2D, 8'h2E})
                    half_op = 1'b1;
                if (op inside {8'h34, 8'h35, 8'h36})
                    mem_op = 1'b1;
            end
            2'b01: begin
                if (op != 8'h76) begin
                    if (src_f == MEM_FIELD || dst_f == MEM_FIELD)
                        mem_op = 1'b1;
                    else if (src_half || dst_half)
                        half_op = 1'b1;
                end
            end
            2'b10: begin
                if (src_f == MEM_FIELD)
                    mem_op = 1'b1;
                else if (src_half)
                    half_op = 1'b1;
            end
            default: begin
                if (op inside {8'hE1, 8'hE3, 8'hE5, 8'hE9, 8'hF9})
                    word_op = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/zps_refresh.sv
module zps_refresh #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] cnt
);

    localparam int LOW_W = CNT_W - 1;

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step)
            cnt_d = {cnt_q[CNT_W-1], cnt_q[LOW_W-1:0] + LOW_W'(1)};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/zps_sequencer.sv
module zps_sequencer
    import zps_pkg::*;
#(
    parameter int REFRESH_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_byte,
    output logic                 in_ready,
    output logic                 dec_valid,
    output logic [1:0]           dec_index,
    output logic [1:0]           dec_page,
    output logic [7:0]           dec_opcode,
    output logic [7:0]           dec_disp,
    output logic                 dec_mem_idx,
    output logic                 dec_half_idx,
    output logic                 dec_copyback,
    output logic                 dec_nop,
    output logic                 dec_pv_ie,
    output logic [REFRESH_W-1:0] refresh_cnt
);

    seq_t s_d;
    seq_t s_q;

    logic       acc;
    logic       step;
    logic       is_x;
    logic       is_y;
    logic       is_pfx;
    logic [1:0] new_idx;
    logic       mem_op;
    logic       half_op;
    logic       word_op;
    rec_t       r;

    zps_classify u_class (
        .op      (in_byte),
        .mem_op  (mem_op),
        .half_op (half_op),
        .word_op (word_op)
    );

    zps_refresh #(.CNT_W(REFRESH_W)) u_refresh (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .cnt   (refresh_cnt)
    );

    assign acc     = in_valid && s_q.rdy;
    assign is_x    = (in_byte == PFX_X);
    assign is_y    = (in_byte == PFX_Y);
    assign is_pfx  = is_x || is_y;
    assign new_idx = is_x ? IDX_X : IDX_Y;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        s_d.rdy = 1'b1;
        step    = 1'b0;
        r       = '0;
        r.op    = in_byte;
        if (acc) begin
            case (s_q.st)
                S_OPEN: begin
                    step = 1'b1;
                    if (is_pfx) begin
                        s_d.st  = S_IDX;
                        s_d.idx = new_idx;
                    end else if (in_byte == PFX_CB) begin
                        s_d.st = S_CB;
                    end else if (in_byte == PFX_ED) begin
                        s_d.st = S_ED;
                    end else begin
                        s_d.rec = r;
                        s_d.vld = 1'b1;
                    end
                end
                S_IDX: begin
                    step = 1'b1;
                    if (is_pfx || in_byte == PFX_ED) begin
                        r.op    = pfx_of(s_q.idx);
                        r.nop   = 1'b1;
                        s_d.rec = r;
                        s_d.vld = 1'b1;
                        if (is_pfx) begin
                            s_d.idx = new_idx;
                        end else begin
                            s_d.idx = IDX_NONE;
                            s_d.st  = S_ED;
                        end
                    end else if (in_byte == PFX_CB) begin
                        s_d.st = S_XCB_D;
                    end else if (mem_op) begin
                        s_d.op = in_byte;
                        s_d.st = S_DISP;
                    end else begin
                        if (half_op || word_op) begin
                            r.idx  = s_q.idx;
                            r.half = half_op;
                        end
                        s_d.rec = r;
                        s_d.vld = 1'b1;
                        s_d.st  = S_OPEN;
                    end
                end
                S_DISP: begin
                    r.idx   = s_q.idx;
                    r.op    = s_q.op;
                    r.disp  = in_byte;
                    r.mem   = 1'b1;
                    s_d.rec = r;
                    s_d.vld = 1'b1;
                    s_d.st  = S_OPEN;
                end
                S_XCB_D: begin
                    s_d.disp = in_byte;
                    s_d.st   = S_XCB_OP;
                end
                S_XCB_OP: begin
                    r.idx   = s_q.idx;
                    r.page  = PG_CB;
                    r.disp  = s_q.disp;
                    r.mem   = 1'b1;
                    r.cb    = (in_byte[2:0] != MEM_FIELD) && (in_byte[7:6] != 2'b01);
                    s_d.rec = r;
                    s_d.vld = 1'b1;
                    s_d.st  = S_OPEN;
                end
                S_CB: begin
                    step    = 1'b1;
                    r.page  = PG_CB;
                    s_d.rec = r;
                    s_d.vld = 1'b1;
                    s_d.st  = S_OPEN;
                end
                default: begin
                    step    = 1'b1;
                    r.page  = PG_ED;
                    r.nop   = (in_byte < 8'h40) || (in_byte >= 8'hC0);
                    r.pv    = (in_byte == 8'h77) || (in_byte == 8'h7F);
                    s_d.rec = r;
                    s_d.vld = 1'b1;
                    s_d.st  = S_OPEN;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.st  <= S_OPEN;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready     = s_q.rdy;
    assign dec_valid    = s_q.vld;
    assign dec_index    = s_q.rec.idx;
    assign dec_page     = s_q.rec.page;
    assign dec_opcode   = s_q.rec.op;
    assign dec_disp     = s_q.rec.disp;
    assign dec_mem_idx  = s_q.rec.mem;
    assign dec_half_idx = s_q.rec.half;
    assign dec_copyback = s_q.rec.cb;
    assign dec_nop      = s_q.rec.nop;
    assign dec_pv_ie    = s_q.rec.pv;

endmodule

// File: rtl/zps_checker.sv
module zps_checker #(
    parameter int REFRESH_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 dec_valid,
    input logic [1:0]           dec_index,
    input logic [1:0]           dec_page,
    input logic [7:0]           dec_opcode,
    input logic                 dec_mem_idx,
    input logic                 dec_half_idx,
    input logic                 dec_copyback,
    input logic                 dec_nop,
    input logic                 dec_pv_ie,
    input logic [REFRESH_W-1:0] refresh_cnt
);

    // R2: a record only follows an accepted byte
    a_r2_record_cause: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(in_valid && in_ready));

    // R12: counter moves only after an accepted byte
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid && in_ready) |-> $stable(refresh_cnt));

    // R12: top bit is never touched
    a_r12_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(refresh_cnt[REFRESH_W-1]));

    // R5: indexed memory operand needs an index register
    a_r5_mem_has_index: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_mem_idx) |-> (dec_index != 2'd0));

    // R6: half-register form never carries a memory operand
    a_r6_half_excl: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !(dec_mem_idx && dec_half_idx));

    // R8: copy-back only on indexed CB with a register field
    a_r8_copyback_form: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_copyback) |->
            (dec_page == 2'd1 && dec_index != 2'd0 && dec_mem_idx && dec_opcode[2:0] != 3'd6));

    // R9: ED no-op only outside 40..BF
    a_r9_ed_nop_range: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_nop && dec_page == 2'd2) |->
            (dec_opcode < 8'h40 || dec_opcode >= 8'hC0));

    // R10: P/V copy only for ED 77 / ED 7F
    a_r10_pv_form: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_pv_ie) |->
            (dec_page == 2'd2 && dec_opcode[7:4] == 4'h7 && dec_opcode[2:0] == 3'd7 && !dec_nop));

endmodule

bind zps_sequencer zps_checker #(.REFRESH_W(REFRESH_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .dec_valid    (dec_valid),
    .dec_index    (dec_index),
    .dec_page     (dec_page),
    .dec_opcode   (dec_opcode),
    .dec_mem_idx  (dec_mem_idx),
    .dec_half_idx (dec_half_idx),
    .dec_copyback (dec_copyback),
    .dec_nop      (dec_nop),
    .dec_pv_ie    (dec_pv_ie),
    .refresh_cnt  (refresh_cnt)
);

// File: tb/zps_sequencer_tb.sv
module zps_sequencer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready;
    logic       dec_valid;
    logic [1:0] dec_index;
    logic [1:0] dec_page;
    logic [7:0] dec_opcode;
    logic [7:0] dec_disp;
    logic       dec_mem_idx;
    logic       dec_half_idx;
    logic       dec_copyback;
    logic       dec_nop;
    logic       dec_pv_ie;
    logic [7:0] refresh_cnt;

    always #2 clk = ~clk;

    zps_sequencer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .in_ready     (in_ready),
        .dec_valid    (dec_valid),
        .dec_index    (dec_index),
        .dec_page     (dec_page),
        .dec_opcode   (dec_opcode),
        .dec_disp     (dec_disp),
        .dec_mem_idx  (dec_mem_idx),
        .dec_half_idx (dec_half_idx),
        .dec_copyback (dec_copyback),
        .dec_nop      (dec_nop),
        .dec_pv_ie    (dec_pv_ie),
        .refresh_cnt  (refresh_cnt)
    );

    typedef struct {
        logic [24:0] bits;
        string       tag;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         errors = 0;
    logic [6:0] exp_r = 7'd0;
    bit         done = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // idx, page, op, disp, mem, half, cb, nop, pv
    task automatic want(input logic [1:0] idx, input logic [1:0] page, input logic [7:0] op,
                        input logic [7:0] disp, input logic mem, input logic half,
                        input logic cb, input logic nop, input logic pv, input string tag);
        exp_t e;
        e.bits = {idx, page, op, disp, mem, half, cb, nop, pv};
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic send(input logic [7:0] b, input bit counts);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        if (counts) exp_r = exp_r + 7'd1;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: compare each record with the scoreboard head
    always @(negedge clk) begin
        if (rst_n && dec_valid) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2 unexpected record op=%0h", dec_opcode);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, 32'({dec_index, dec_page, dec_opcode, dec_disp, dec_mem_idx,
                                  dec_half_idx, dec_copyback, dec_nop, dec_pv_ie}), 32'(e.bits));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 valid", 32'(dec_valid), 32'd0);
        check("R1 refresh", 32'(refresh_cnt), 32'd0);
        check("R1 ready", 32'(in_ready), 32'd1);

        // R2: plain byte, one-cycle pulse
        want(0, 0, 8'h3C, 0, 0, 0, 0, 0, 0, "R2 plain");
        send(8'h3C, 1);
        idle();
        @(negedge clk);
        check("R2 pulse width", 32'(dec_valid), 32'd0);

        // R3: word HL forms
        want(1, 0, 8'h21, 0, 0, 0, 0, 0, 0, "R3 DD 21");
        send(8'hDD, 1); send(8'h21, 1);
        want(2, 0, 8'h09, 0, 0, 0, 0, 0, 0, "R3 FD 09");
        send(8'hFD, 1); send(8'h09, 1);
        want(2, 0, 8'hE9, 0, 0, 0, 0, 0, 0, "R3 FD E9");
        send(8'hFD, 1); send(8'hE9, 1);

        // R4: dropped prefix
        want(0, 0, 8'hFF, 0, 0, 0, 0, 0, 0, "R4 DD FF");
        send(8'hDD, 1); send(8'hFF, 1);
        want(0, 0, 8'h76, 0, 0, 0, 0, 0, 0, "R4 FD 76");
        send(8'hFD, 1); send(8'h76, 1);

        // R5: indexed memory with displacement
        want(1, 0, 8'h86, 8'h05, 1, 0, 0, 0, 0, "R5 DD 86 05");
        send(8'hDD, 1); send(8'h86, 1); send(8'h05, 0);
        want(2, 0, 8'h36, 8'h80, 1, 0, 0, 0, 0, "R5 FD 36 80");
        send(8'hFD, 1); send(8'h36, 1); send(8'h80, 0);

        // R6: halves versus memory operand
        want(2, 0, 8'h44, 0, 0, 1, 0, 0, 0, "R6 FD 44");
        send(8'hFD, 1); send(8'h44, 1);
        want(1, 0, 8'h24, 0, 0, 1, 0, 0, 0, "R6 DD 24");
        send(8'hDD, 1); send(8'h24, 1);
        want(1, 0, 8'h66, 8'hF0, 1, 0, 0, 0, 0, "R6 DD 66 F0");
        send(8'hDD, 1); send(8'h66, 1); send(8'hF0, 0);

        // R7 / R8: indexed CB ordering and copy-back
        want(2, 1, 8'h06, 8'h10, 1, 0, 0, 0, 0, "R7 FD CB 10 06");
        send(8'hFD, 1); send(8'hCB, 1); send(8'h10, 0); send(8'h06, 0);
        want(1, 1, 8'hC0, 8'h80, 1, 0, 1, 0, 0, "R8 DD CB 80 C0");
        send(8'hDD, 1); send(8'hCB, 1); send(8'h80, 0); send(8'hC0, 0);
        want(1, 1, 8'h46, 8'h01, 1, 0, 0, 0, 0, "R8 DD CB 01 46");
        send(8'hDD, 1); send(8'hCB, 1); send(8'h01, 0); send(8'h46, 0);
        want(2, 1, 8'h45, 8'h7F, 1, 0, 0, 0, 0, "R8 bit test no copyback");
        send(8'hFD, 1); send(8'hCB, 1); send(8'h7F, 0); send(8'h45, 0);

        // R13: plain CB
        want(0, 1, 8'h11, 0, 0, 0, 0, 0, 0, "R13 CB 11");
        send(8'hCB, 1); send(8'h11, 1);

        // R9 / R10: ED page
        want(0, 2, 8'h00, 0, 0, 0, 0, 1, 0, "R9 ED 00");
        send(8'hED, 1); send(8'h00, 1);
        want(0, 2, 8'hFF, 0, 0, 0, 0, 1, 0, "R9 ED FF");
        send(8'hED, 1); send(8'hFF, 1);
        want(0, 2, 8'hB0, 0, 0, 0, 0, 0, 0, "R9 ED B0");
        send(8'hED, 1); send(8'hB0, 1);
        want(0, 2, 8'h44, 0, 0, 0, 0, 0, 0, "R9 ED 44");
        send(8'hED, 1); send(8'h44, 1);
        want(0, 2, 8'h77, 0, 0, 0, 0, 0, 1, "R10 ED 77");
        send(8'hED, 1); send(8'h77, 1);
        want(0, 2, 8'h7F, 0, 0, 0, 0, 0, 1, "R10 ED 7F");
        send(8'hED, 1); send(8'h7F, 1);

        // R11: stacked prefixes
        want(0, 0, 8'hDD, 0, 0, 0, 0, 1, 0, "R11 retired DD");
        want(2, 0, 8'h21, 0, 0, 0, 0, 0, 0, "R11 last prefix FD");
        send(8'hDD, 1); send(8'hFD, 1); send(8'h21, 1);
        want(0, 0, 8'hFD, 0, 0, 0, 0, 1, 0, "R11 retired FD");
        want(0, 2, 8'h4A, 0, 0, 0, 0, 0, 0, "R11 ED after prefix");
        send(8'hFD, 1); send(8'hED, 1); send(8'h4A, 1);
        idle();
        repeat (2) @(negedge clk);
        check("R12 count after mix", 32'(refresh_cnt), 32'({1'b0, exp_r}));

        // R12: wrap of the low 7 bits
        for (int i = 0; i < 130; i++) begin
            want(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R12 filler");
            send(8'h00, 1);
        end
        idle();
        repeat (2) @(negedge clk);
        check("R12 wrap", 32'(refresh_cnt), 32'({1'b0, exp_r}));

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule